// File: doc/BRIEF.md
# Buffered-Duty PWM Timer

This block is an up-counter PWM generator. A period compare value fixes how many count strobes make up one PWM cycle, and a duty compare value fixes where in that cycle the output drops back to its idle level. On every period match the counter returns to zero, the output turns active and a single-cycle interrupt pulse is raised. A later duty match only returns the output to idle. It does not clear the counter and it raises no interrupt.

Software may rewrite the duty compare value at any moment while the timer runs. The new value waits in a holding latch. It moves into the working duty register only on a duty match against the old value, and only if that match falls on the third or a later count strobe after the write. This keeps a half-applied duty value from ever producing a glitch. The period value is fixed while the timer runs. The counter advances on a one-cycle strobe input, so an external prescaler decides the count rate.

Top module: `pwm_duty_timer`

## Requirements
- R1: After the run bit goes from 0 to 1, the first count strobe is swallowed. With period value P, the first interrupt pulse follows the (P+2)-th strobe after enabling, and re-enabling always starts again from count 0.
- R2: From enable until the first period match, the output stays at its idle level.
- R3: When the count equals P on a strobe, the count returns to 0, the output turns active and `period_irq` is high for exactly one clock. With a strobe every clock, interrupts are P+1 clocks apart.
- R4: When the count equals the working duty value D on a strobe (and P does not also match), the output returns to idle, the count keeps running and no interrupt is raised. The output is active for min(D,P)+1 strobes per cycle: D=0 gives one strobe, and D>=P keeps it active for the whole cycle.
- R5: A duty write while running is held. It is committed on a match against the old duty value on the third or a later strobe after the write. A match on the first or second strobe after the write, or in the cycle of the write itself, does not commit it, and the commit waits for a later match.
- R6: Writing run=0 makes the output idle and `period_irq` low by the second clock edge after the write, and resets the count to 0.
- R7: With `ctl_invert`=0 the active level is 1 and the idle level is 0. With `ctl_invert`=1 both levels are swapped.
- R8: A period write while the run bit is 1 has no effect. While the run bit is 0, a period write is stored.
- R9: While stopped, the working duty register follows the last written duty value, so a duty written while stopped governs the first cycle after enabling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Strobe that loads the run and invert bits |
| ctl_run | input | 1 | Run bit value: 1 counts, 0 stops and clears |
| ctl_invert | input | 1 | Output polarity: 1 swaps the active and idle levels |
| period_we | input | 1 | Period compare write strobe |
| period_data | input | 8 | Period compare value |
| duty_we | input | 1 | Duty compare write strobe |
| duty_data | input | 8 | Duty compare value |
| cnt_tick | input | 1 | Single-cycle count strobe |
| pwm_out | output | 1 | PWM waveform |
| period_irq | output | 1 | One-clock pulse on each period match |

## Verification
The bench sweeps every pairing of small period and duty values under both polarities. It measures the interrupt spacing and the active time against P+1 and min(D,P)+1. A design that gave priority to the duty match over the period match, or that treated D=0 or D=P wrongly, would show an off-by-one active time. The bench places duty writes exactly one, three and zero strobes before the old-value match. A design with a wrong gap count would commit the new value one PWM cycle early or late, and this shows as a misplaced change in active time. It also counts strobes up to the first interrupt after enabling and after re-enabling. A design that forgot to swallow the first strobe, or to clear the count on stop, would fire one strobe early. It also writes a period while running and checks that the interrupt spacing keeps its old value.

// File: rtl/pwm_tmr_pkg.sv
// Shared types for the buffered-duty PWM timer.
// Assumes: nothing beyond standard SystemVerilog.
package pwm_tmr_pkg;

    // Control bits loaded together by one control write
    typedef struct packed {
        logic run;
        logic invert;
    } pwm_ctl_t;

endpackage

// File: rtl/pwm_tmr_regs.sv
// Configuration registers: control bits, period compare, duty holding latch
// and working duty register with its commit gap counter.
// Assumes: duty_hit is only ever high together with a count strobe while
// running; GAP >= 2.
module pwm_tmr_regs
    import pwm_tmr_pkg::*;
#(
    parameter int W   = 8,
    parameter int GAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          ctl_run,
    input  logic          ctl_invert,
    input  logic          period_we,
    input  logic [W-1:0]  period_data,
    input  logic          duty_we,
    input  logic [W-1:0]  duty_data,
    input  logic          tick,
    input  logic          duty_hit,
    output pwm_ctl_t      ctl_q,
    output logic [W-1:0]  period_q,
    output logic [W-1:0]  duty_act_q
);

    localparam int            GW       = $clog2(GAP + 1);
    localparam logic [GW-1:0] GAP_SAT  = GW'(GAP);
    localparam logic [GW-1:0] GAP_NEED = GW'(GAP - 1);

    logic [W-1:0]  duty_hold_q;
    logic          pend_q;
    logic [GW-1:0] gap_q;
    logic          commit;

    // A held value commits on an old-value match at least GAP strobes after the write
    assign commit = pend_q && duty_hit && !duty_we && (gap_q >= GAP_NEED);

    // Control bits
    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (ctl_we) ctl_q <= '{run: ctl_run, invert: ctl_invert};
    end

    // Period compare, writable only while stopped
    always_ff @(posedge clk) begin
        if (!rst_n)                        period_q <= '1;
        else if (period_we && !ctl_q.run)  period_q <= period_data;
    end

    // Duty holding latch takes every write
    always_ff @(posedge clk) begin
        if (!rst_n)       duty_hold_q <= '0;
        else if (duty_we) duty_hold_q <= duty_data;
    end

    // Pending flag and strobe gap counter since the last running write
    always_ff @(posedge clk) begin
        if (!rst_n || !ctl_q.run) begin
            pend_q <= 1'b0;
            gap_q  <= '0;
        end else if (duty_we) begin
            pend_q <= 1'b1;
            gap_q  <= '0;
        end else begin
            if (tick && gap_q != GAP_SAT) gap_q <= gap_q + 1'b1;
            if (commit)                   pend_q <= 1'b0;
        end
    end

    // Working duty: follows the latch while stopped, commits while running
    always_ff @(posedge clk) begin
        if (!rst_n)          duty_act_q <= '0;
        else if (!ctl_q.run) duty_act_q <= duty_hold_q;
        else if (commit)     duty_act_q <= duty_hold_q;
    end

endmodule

// File: rtl/pwm_tmr_count.sv
// Up-counter with a swallowed first strobe, and the period and duty match
// strobes. The period match takes priority over the duty match.
// Assumes: tick is a one-clock strobe; run low clears all state.
module pwm_tmr_count #(
    parameter int W = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          tick,
    input  logic [W-1:0]  period,
    input  logic [W-1:0]  duty,
    output logic [W-1:0]  cnt_q,
    output logic          per_hit,
    output logic          duty_hit
);

    logic armed_q;
    logic live;

    assign live     = run && tick && armed_q;
    assign per_hit  = live && (cnt_q == period);
    assign duty_hit = live && (cnt_q == duty) && !per_hit;

    // Arming: the first strobe after enable only arms the counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run) armed_q <= 1'b0;
        else if (tick)      armed_q <= 1'b1;
    end

    // Count: clear on a period match, otherwise step on each live strobe
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt_q <= '0;
        else if (per_hit)   cnt_q <= '0;
        else if (live)      cnt_q <= cnt_q + 1'b1;
    end

endmodule

// File: rtl/pwm_tmr_wave.sv
// Output level and interrupt pulse generation from the match strobes.
// Assumes: per_hit and duty_hit are never high together.
module pwm_tmr_wave (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic invert,
    input  logic per_hit,
    input  logic duty_hit,
    output logic active_q,
    output logic irq_q,
    output logic pwm_out
);

    // Active phase: set on a period match, cleared on a duty match or stop
    always_ff @(posedge clk) begin
        if (!rst_n || !run) active_q <= 1'b0;
        else if (per_hit)   active_q <= 1'b1;
        else if (duty_hit)  active_q <= 1'b0;
    end

    // Interrupt: one clock after each period match
    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= run && per_hit;
    end

    assign pwm_out = active_q ^ invert;

endmodule

// File: rtl/pwm_duty_timer.sv
// Top of the buffered-duty PWM timer: registers, counter and output stage.
// Assumes: all inputs synchronous to clk; cnt_tick comes from a prescaler.
module pwm_duty_timer
    import pwm_tmr_pkg::*;
#(
    parameter int W   = 8,
    parameter int GAP = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_we,
    input  logic          ctl_run,
    input  logic          ctl_invert,
    input  logic          period_we,
    input  logic [W-1:0]  period_data,
    input  logic          duty_we,
    input  logic [W-1:0]  duty_data,
    input  logic          cnt_tick,
    output logic          pwm_out,
    output logic          period_irq
);

    pwm_ctl_t     ctl_q;
    logic         run_w;
    logic         inv_w;
    logic [W-1:0] period_q;
    logic [W-1:0] duty_act_q;
    logic [W-1:0] cnt_q;
    logic         per_hit;
    logic         duty_hit;
    logic         active_q;

    assign run_w = ctl_q.run;
    assign inv_w = ctl_q.invert;

    pwm_tmr_regs #(.W(W), .GAP(GAP)) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctl_we      (ctl_we),
        .ctl_run     (ctl_run),
        .ctl_invert  (ctl_invert),
        .period_we   (period_we),
        .period_data (period_data),
        .duty_we     (duty_we),
        .duty_data   (duty_data),
        .tick        (cnt_tick),
        .duty_hit    (duty_hit),
        .ctl_q       (ctl_q),
        .period_q    (period_q),
        .duty_act_q  (duty_act_q)
    );

    pwm_tmr_count #(.W(W)) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .tick     (cnt_tick),
        .period   (period_q),
        .duty     (duty_act_q),
        .cnt_q    (cnt_q),
        .per_hit  (per_hit),
        .duty_hit (duty_hit)
    );

    pwm_tmr_wave u_wave (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_w),
        .invert   (inv_w),
        .per_hit  (per_hit),
        .duty_hit (duty_hit),
        .active_q (active_q),
        .irq_q    (period_irq),
        .pwm_out  (pwm_out)
    );

endmodule

// File: rtl/pwm_duty_timer_chk.sv
// Property checker for the buffered-duty PWM timer, bound to the top.
// Assumes: sampled on the rising clk edge, disabled during reset.
module pwm_duty_timer_chk #(
    parameter int W = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          run,
    input logic          invert,
    input logic [W-1:0]  cnt,
    input logic [W-1:0]  period,
    input logic [W-1:0]  duty_act,
    input logic          per_hit,
    input logic          duty_hit,
    input logic          active,
    input logic          irq,
    input logic          pwm_out
);

    // R1: freshly enabled timer starts from count 0, idle
    a_r1_start_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !$past(run)) |-> (cnt == '0 && !active));

    // R3: period match clears the count, turns active, raises the pulse
    a_r3_period_match: assert property (@(posedge clk) disable iff (!rst_n)
        per_hit |=> (cnt == '0 && active && irq));

    // R3: an interrupt pulse always coincides with the active phase
    a_r3_irq_active: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> active);

    // R4: duty match idles the output, raises no interrupt, keeps counting
    a_r4_duty_match: assert property (@(posedge clk) disable iff (!rst_n)
        duty_hit |=> (!active && !irq && cnt != '0));

    // R5: while running, the working duty only changes on a duty match
    a_r5_commit_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(run) && !$stable(duty_act)) |-> $past(duty_hit));

    // R6: a stopped timer has an idle output, no pulse and a zero count
    a_r6_stop_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!active && !irq && cnt == '0));

    // R7: while stopped for two cycles the output sits at the idle level
    a_r7_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !$past(run)) |-> (pwm_out == invert));

    // R8: period compare holds while running
    a_r8_period_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(period));

endmodule

bind pwm_duty_timer pwm_duty_timer_chk #(.W(W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_w),
    .invert   (inv_w),
    .cnt      (cnt_q),
    .period   (period_q),
    .duty_act (duty_act_q),
    .per_hit  (per_hit),
    .duty_hit (duty_hit),
    .active   (active_q),
    .irq      (period_irq),
    .pwm_out  (pwm_out)
);

// File: tb/pwm_duty_timer_bench.sv
// Self-checking bench: sweeps period/duty pairs and polarities, then runs
// directed checks on start-up, stop, period lock and buffered duty commits.
module pwm_duty_timer_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_we = 1'b0, ctl_run = 1'b0, ctl_invert = 1'b0;
    logic       period_we = 1'b0, duty_we = 1'b0, cnt_tick = 1'b0;
    logic [7:0] period_data = '0, duty_data = '0;
    logic       pwm_out, period_irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    always #2.5 clk = ~clk;

    pwm_duty_timer u_pwm_duty_timer (
        .clk(clk), .rst_n(rst_n),
        .ctl_we(ctl_we), .ctl_run(ctl_run), .ctl_invert(ctl_invert),
        .period_we(period_we), .period_data(period_data),
        .duty_we(duty_we), .duty_data(duty_data),
        .cnt_tick(cnt_tick),
        .pwm_out(pwm_out), .period_irq(period_irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr_ctl(input bit run, input bit inv);
        ctl_we = 1'b1; ctl_run = run; ctl_invert = inv;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr_per(input int v);
        period_we = 1'b1; period_data = 8'(v);
        @(negedge clk);
        period_we = 1'b0;
    endtask

    task automatic wr_duty(input int v);
        duty_we = 1'b1; duty_data = 8'(v);
        @(negedge clk);
        duty_we = 1'b0;
    endtask

    task automatic wait_irq();
        int n = 0;
        while (!period_irq && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (!period_irq) chk(1'b0, "R3 interrupt timeout", n, 0);
    endtask

    // Starts on a pulse cycle (count 0), ends on the next pulse cycle.
    // Optionally writes a duty value in the cycle where the count equals k.
    task automatic measure(input bit inv, input bit do_wr, input int k,
                           input int val, output int len, output int hi);
        len = 0; hi = 0;
        do begin
            if (pwm_out != inv) hi++;
            duty_we   = do_wr && (len == k);
            duty_data = 8'(val);
            @(negedge clk);
            len++;
        end while (!period_irq && len < 2000);
        duty_we = 1'b0;
    endtask

    task automatic setup(input int p, input int d, input bit inv);
        wr_ctl(1'b0, inv);
        wr_per(p);
        wr_duty(d);
        wr_ctl(1'b1, inv);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                chk(1'b0, "watchdog", cyc, 150000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
                $finish;
            end
        end
    end

    initial begin
        int len, hi, n, exp_hi;
        repeat (3) @(negedge clk);
        chk(pwm_out == 1'b0, "R7 reset output", int'(pwm_out), 0);
        chk(period_irq == 1'b0, "R3 reset irq", int'(period_irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 / R2: strobe by strobe up to the first interrupt, P=3
        setup(3, 1, 1'b0);
        for (int i = 1; i <= 5; i++) begin
            cnt_tick = 1'b1;
            @(negedge clk);
            cnt_tick = 1'b0;
            chk(period_irq == (i == 5), "R1 first pulse after P+2 strobes", int'(period_irq), int'(i == 5));
            if (i < 5) chk(pwm_out == 1'b0, "R2 idle before first match", int'(pwm_out), 0);
            @(negedge clk);
            chk(period_irq == 1'b0, "R3 pulse lasts one clock", int'(period_irq), 0);
        end

        // Sweep: all small period/duty pairs, both polarities (R3, R4, R7)
        cnt_tick = 1'b1;
        for (int inv = 0; inv < 2; inv++) begin
            for (int p = 1; p <= 10; p++) begin
                for (int d = 0; d <= 11; d++) begin
                    setup(p, d, inv[0]);
                    wait_irq();
                    measure(inv[0], 1'b0, 0, 0, len, hi);
                    exp_hi = ((d < p) ? d : p) + 1;
                    chk(len == p + 1, "R3 pulse spacing", len, p + 1);
                    chk(hi == exp_hi, inv ? "R7 inverted active time" : "R4 active time", hi, exp_hi);
                end
            end
        end

        // R6: stop while active, then restart from count 0
        setup(3, 2, 1'b0);
        wait_irq();
        wr_ctl(1'b0, 1'b0);
        @(negedge clk);
        chk(pwm_out == 1'b0, "R6 stop idles output", int'(pwm_out), 0);
        chk(period_irq == 1'b0, "R6 stop drops irq", int'(period_irq), 0);
        wr_ctl(1'b1, 1'b0);
        n = 0;
        while (!period_irq && n < 100) begin
            @(negedge clk);
            n++;
        end
        chk(n == 5, "R6 R1 restart from zero", n, 5);

        // R7: stopped with inversion gives a high idle level
        wr_ctl(1'b0, 1'b1);
        @(negedge clk);
        chk(pwm_out == 1'b1, "R7 inverted idle level", int'(pwm_out), 1);

        // R8: period write while running is ignored, accepted when stopped
        setup(6, 2, 1'b0);
        wait_irq();
        wr_per(3);
        wait_irq();
        measure(1'b0, 1'b0, 0, 0, len, hi);
        chk(len == 7, "R8 running period write ignored", len, 7);
        setup(3, 1, 1'b0);
        wait_irq();
        measure(1'b0, 1'b0, 0, 0, len, hi);
        chk(len == 4, "R8 stopped period write stored", len, 4);

        // R9: duty written while stopped governs the first cycle
        setup(9, 1, 1'b0);
        wr_ctl(1'b0, 1'b0);
        wr_duty(4);
        wr_ctl(1'b1, 1'b0);
        wait_irq();
        measure(1'b0, 1'b0, 0, 0, len, hi);
        chk(hi == 5, "R9 stopped duty applied at enable", hi, 5);

        // R5: write one strobe before the old match: commit one cycle later
        setup(20, 8, 1'b0);
        wait_irq();
        measure(1'b0, 1'b1, 7, 14, len, hi);
        chk(hi == 9, "R5 late write keeps old duty", hi, 9);
        measure(1'b0, 1'b0, 0, 0, len, hi);
        chk(hi == 9, "R5 commit on following match", hi, 9);
        measure(1'b0, 1'b0, 0, 0, len, hi);
        chk(hi == 15, "R5 new duty after commit", hi, 15);

        // R5: write three strobes before the old match: commit at once
        measure(1'b0, 1'b1, 11, 4, len, hi);
        chk(hi == 15, "R5 early write old duty this cycle", hi, 15);
        measure(1'b0, 1'b0, 0, 0, len, hi);
        chk(hi == 5, "R5 early write committed", hi, 5);

        // R5: write in the match cycle itself: no commit on that match
        measure(1'b0, 1'b1, 4, 10, len, hi);
        chk(hi == 5, "R5 same-cycle write", hi, 5);
        measure(1'b0, 1'b0, 0, 0, len, hi);
        chk(hi == 5, "R5 same-cycle commit next match", hi, 5);
        measure(1'b0, 1'b0, 0, 0, len, hi);
        chk(hi == 11, "R5 same-cycle new duty", hi, 11);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

endmodule